// File: doc/BRIEF.md
# Timed ROM Bank Sequencer

This block sits between an 8-bit host's memory bus and a cartridge ROM that is larger than the host's 16K ROM window. It enables the ROM only when the host addresses the bottom 16K of its map. With no software involvement, it then walks through a fixed list of 16K banks, keeping each bank mapped for a programmable number of clock cycles. The list depends on a configuration code. The host-side software copies each bank to RAM while it is mapped, and it notices a bank change when the data in the window changes.

Between two banks the block leaves the window dark for a short, separately programmed gap. During the gap no chip enable is driven, so reads of the window return all ones. Some configurations end by handing the window back to the host's internal ROM: the cartridge-present output drops, and the chip enable stays off until the next reset. The other configurations keep their final bank mapped for good. The interval defaults to about 0.7 s at 125 MHz. Both lengths are parameters, so a simulation can use short values.

Top module: `rom_bank_sequencer`

## Requirements
- R1: `rom_ce_n` is low only when `host_a15` and `host_a14` are both 0 and a bank is currently mapped. For every other address it is high.
- R2: Configuration codes 0, 1 and 3 release the window after their last bank. Code 0 maps bank 0 only. Code 1 maps bank 0 and then bank 1. Code 3 maps bank 0, then bank 1, then bank 3.
- R3: Code 2 maps bank 0, then bank 1, then bank 3. Bank 3 then stays mapped permanently.
- R4: Code 4 maps bank 1, then bank 0, then bank 2, then bank 3. Bank 3 stays mapped, and `cart_present` never falls.
- R5: Each bank is mapped for exactly INTERVAL_CYCLES clocks. After `rst_n` rises there are two synchronizer cycles, so the first bank stays mapped through clock edge INTERVAL_CYCLES+1 counted from the release. Every later bank starts INTERVAL_CYCLES+GAP_CYCLES edges after the one before it.
- R6: After each mapped bank that is not permanent, a gap of GAP_CYCLES clocks follows. During the gap `rom_ce_n` is high and `cart_present` is high. `bank_addr` switches to the next bank when the gap starts and holds steady while a bank is mapped.
- R7: After the gap that follows the last bank of a releasing configuration, `cart_present` is 0 and `rom_ce_n` is 1 for every address until the next reset. `bank_addr` keeps the last bank.
- R8: `cfg_sel` is sampled only while reset is active. Changing it later has no effect on the sequence.
- R9: While `rst_n` is low, and after every reset, the sequence starts over at its first step: that step's bank is mapped and `cart_present` is 1.
- R10: Codes 5, 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_a15 | input | 1 | Host address bit 15 |
| host_a14 | input | 1 | Host address bit 14 |
| cfg_sel | input | 3 | Bank order code, sampled during reset |
| rom_ce_n | output | 1 | Active-low cartridge ROM chip enable |
| bank_addr | output | 2 | Upper ROM address bits selecting the 16K bank |
| cart_present | output | 1 | High while the cartridge owns the window; the host's internal ROM is disabled |

## Verification
The chip enable follows the host address bits combinationally in the same cycle. Every phase change is due on a clock edge that can be counted exactly from the release of reset: the first change comes INTERVAL_CYCLES+2 edges after `rst_n` rises, and each later one after a further INTERVAL_CYCLES or GAP_CYCLES edges. The bench counts edges from the release and, at each falling edge, queues the expected outputs for the state left by the preceding rising edge. A monitor compares those outputs a short delay later, so the boundary cycles of every bank and gap are checked on the exact cycle.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int BANK_W = 2;
  localparam int STEP_W = 3;
  localparam int CFG_W  = 3;

  localparam logic [CFG_W-1:0] CFG_ONE_OUT    = 3'd0;
  localparam logic [CFG_W-1:0] CFG_TWO_OUT    = 3'd1;
  localparam logic [CFG_W-1:0] CFG_THREE_HOLD = 3'd2;
  localparam logic [CFG_W-1:0] CFG_THREE_OUT  = 3'd3;
  localparam logic [CFG_W-1:0] CFG_FOUR_HOLD  = 3'd4;

  typedef enum logic [1:0] {
    PH_MAP = 2'd0,
    PH_GAP = 2'd1,
    PH_OFF = 2'd2
  } phase_t;

  function automatic logic [STEP_W-1:0] seq_len(input logic [CFG_W-1:0] cfg);
    case (cfg)
      CFG_TWO_OUT:                   return 3'd2;
      CFG_THREE_HOLD, CFG_THREE_OUT: return 3'd3;
      CFG_FOUR_HOLD:                 return 3'd4;
      default:                       return 3'd1;
    endcase
  endfunction

  function automatic logic seq_release(input logic [CFG_W-1:0] cfg);
    return !((cfg == CFG_THREE_HOLD) || (cfg == CFG_FOUR_HOLD));
  endfunction

  // Step indices past the end clamp to the final entry.
  function automatic logic [BANK_W-1:0] seq_bank(input logic [CFG_W-1:0]  cfg,
                                                 input logic [STEP_W-1:0] step);
    logic [STEP_W-1:0] len;
    logic [STEP_W-1:0] idx;
    len = seq_len(cfg);
    idx = (step >= len) ? (len - 3'd1) : step;
    case (cfg)
      CFG_TWO_OUT:                   return idx[BANK_W-1:0];
      CFG_THREE_HOLD, CFG_THREE_OUT: return (idx == 3'd2) ? 2'd3 : idx[BANK_W-1:0];
      CFG_FOUR_HOLD:                 return (idx == 3'd0) ? 2'd1 :
                                            (idx == 3'd1) ? 2'd0 : idx[BANK_W-1:0];
      default:                       return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/rbs_rst_sync.sv
module rbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES:0] chain;

  assign chain[0] = 1'b1;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= 1'b0;
      else        chain[g+1] <= chain[g];
    end
  end

  assign rst_sync_n = chain[STAGES];

endmodule

// File: rtl/rbs_timer.sv
module rbs_timer #(
  parameter int unsigned INTERVAL_CYCLES = 87_500_000,
  parameter int unsigned GAP_CYCLES      = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_gap,
  output logic expire
);

  localparam int unsigned LONGEST = (INTERVAL_CYCLES > GAP_CYCLES) ? INTERVAL_CYCLES : GAP_CYCLES;
  localparam int          CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] LIM_MAP = CNT_W'(INTERVAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIM_GAP = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    expire = run && (cnt_q == (sel_gap ? LIM_GAP : LIM_MAP));
    cnt_d  = expire ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rbs_order.sv
module rbs_order
  import rbs_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg,
  input  logic [STEP_W-1:0] step,
  output logic [BANK_W-1:0] bank,
  output logic [STEP_W-1:0] len,
  output logic              release_en
);

  always_comb begin
    bank       = seq_bank(cfg, step);
    len        = seq_len(cfg);
    release_en = seq_release(cfg);
  end

endmodule

// File: rtl/rom_bank_sequencer.sv
module rom_bank_sequencer
  import rbs_pkg::*;
#(
  parameter int unsigned INTERVAL_CYCLES = 87_500_000,
  parameter int unsigned GAP_CYCLES      = 16,
  parameter int          SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_a15,
  input  logic              host_a14,
  input  logic [CFG_W-1:0]  cfg_sel,
  output logic              rom_ce_n,
  output logic [BANK_W-1:0] bank_addr,
  output logic              cart_present
);

  logic              rst_q_n;
  logic [CFG_W-1:0]  cfg_q;
  logic              cfg_ld;
  phase_t            ph_q, ph_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [STEP_W-1:0] len;
  logic              release_en;
  logic              last_step;
  logic              run;
  logic              tick;

  rbs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // Configuration register: loaded only while reset is held.
  assign cfg_ld = !rst_q_n;

  always_ff @(posedge clk) begin
    if (cfg_ld) cfg_q <= cfg_sel;
  end

  rbs_order u_order (
    .cfg        (cfg_q),
    .step       (step_q),
    .bank       (bank_addr),
    .len        (len),
    .release_en (release_en)
  );

  assign last_step = (step_q == (len - STEP_W'(1)));
  assign run       = (ph_q == PH_GAP) ||
                     ((ph_q == PH_MAP) && !(last_step && !release_en));

  rbs_timer #(
    .INTERVAL_CYCLES (INTERVAL_CYCLES),
    .GAP_CYCLES      (GAP_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .run     (run),
    .sel_gap (ph_q == PH_GAP),
    .expire  (tick)
  );

  always_comb begin
    ph_d   = ph_q;
    step_d = step_q;
    case (ph_q)
      PH_MAP: begin
        if (tick) begin
          ph_d   = PH_GAP;
          step_d = step_q + STEP_W'(1);
        end
      end
      PH_GAP: begin
        if (tick) ph_d = (step_q == len) ? PH_OFF : PH_MAP;
      end
      default: ph_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ph_q   <= PH_MAP;
      step_q <= '0;
    end else begin
      ph_q   <= ph_d;
      step_q <= step_d;
    end
  end

  assign rom_ce_n     = !((ph_q == PH_MAP) && !host_a15 && !host_a14);
  assign cart_present = (ph_q != PH_OFF);

endmodule

// File: rtl/rom_bank_sequencer_chk.sv
module rom_bank_sequencer_chk
  import rbs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_a15,
  input logic              host_a14,
  input logic              rom_ce_n,
  input logic [BANK_W-1:0] bank_addr,
  input logic              cart_present,
  input phase_t            ph,
  input logic [STEP_W-1:0] step,
  input logic [CFG_W-1:0]  cfg
);

  // R1
  a_r1_ce_decode: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> (!host_a15 && !host_a14));

  // R6
  a_r6_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_GAP) |-> (rom_ce_n && cart_present));

  // R6
  a_r6_bank_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_MAP) ##1 (ph == PH_MAP) |-> $stable(bank_addr));

  // R7
  a_r7_off_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cart_present |=> !cart_present);

  // R7
  a_r7_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !cart_present |-> rom_ce_n);

  // R4
  a_r4_never_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == CFG_FOUR_HOLD) |-> cart_present);

  // R3
  a_r3_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg == CFG_THREE_HOLD) && (ph == PH_MAP) && (step == 3'd2))
      |=> ((ph == PH_MAP) && (bank_addr == 2'd3)));

endmodule

bind rom_bank_sequencer rom_bank_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_a15     (host_a15),
  .host_a14     (host_a14),
  .rom_ce_n     (rom_ce_n),
  .bank_addr    (bank_addr),
  .cart_present (cart_present),
  .ph           (ph_q),
  .step         (step_q),
  .cfg          (cfg_q)
);

// File: tb/rom_bank_sequencer_tb.sv
module rom_bank_sequencer_tb;

  localparam int IV = 40;
  localparam int GP = 5;
  localparam int PER = IV + GP;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_a15, host_a14;
  logic [2:0] cfg_sel;
  wire        rom_ce_n;
  wire  [1:0] bank_addr;
  wire        cart_present;

  always #4 clk = ~clk;

  rom_bank_sequencer #(
    .INTERVAL_CYCLES (IV),
    .GAP_CYCLES      (GP)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_a15     (host_a15),
    .host_a14     (host_a14),
    .cfg_sel      (cfg_sel),
    .rom_ce_n     (rom_ce_n),
    .bank_addr    (bank_addr),
    .cart_present (cart_present)
  );

  typedef struct {
    logic       ce_n;
    logic [1:0] bank;
    logic       pres;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  int   n     = 0;
  int   pat   = 0;
  bit   done  = 0;

  // Edges since rst_n rose.
  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  // Independent bank order table from the requirements.
  function automatic int m_len(int c);
    case (c)
      1: return 2;
      2, 3: return 3;
      4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic bit m_rel(int c);
    return !(c == 2 || c == 4);
  endfunction

  function automatic int m_bank(int c, int i);
    int b0[4] = '{0, 0, 0, 0};
    int b1[4] = '{0, 1, 1, 1};
    int b3[4] = '{0, 1, 3, 3};
    int b4[4] = '{1, 0, 2, 3};
    case (c)
      1: return b1[i];
      2, 3: return b3[i];
      4: return b4[i];
      default: return b0[i];
    endcase
  endfunction

  function automatic exp_t model(int c, int nn, logic a15, logic a14, bit in_rst, bit swapped);
    exp_t e;
    int i, r, len;
    bit mapped, off, gap;
    len = m_len(c);
    if (nn < 2 + IV) begin i = 0; r = nn - 2; end
    else begin i = (nn - 2) / PER; r = (nn - 2) % PER; end
    mapped = 0; off = 0; gap = 0;
    if (!m_rel(c) && i >= len - 1) begin
      mapped = 1; e.bank = 2'(m_bank(c, len - 1));
    end else if (i >= len) begin
      off = 1; e.bank = 2'(m_bank(c, len - 1));
    end else if (r < IV) begin
      mapped = 1; e.bank = 2'(m_bank(c, i));
    end else begin
      gap = 1; e.bank = 2'(m_bank(c, (i + 1 < len) ? i + 1 : len - 1));
    end
    e.ce_n = !(mapped && !a15 && !a14);
    e.pres = !off;
    if (in_rst)                                  e.tag = "R9";
    else if (swapped)                            e.tag = "R8";
    else if (off)                                e.tag = "R7";
    else if (gap)                                e.tag = "R6";
    else if (mapped && (r == IV - 1 || r == 0))  e.tag = "R5";
    else if (a15 || a14)                         e.tag = "R1";
    else if (c >= 5)                             e.tag = "R10";
    else if (c == 2)                             e.tag = "R3";
    else if (c == 4)                             e.tag = "R4";
    else                                         e.tag = "R2";
    return e;
  endfunction

  // Driver: set address lines, queue expected outputs.
  task automatic drive(int c, bit in_rst, bit swapped);
    logic [1:0] a;
    a = 2'((pat * 3 + pat / 4) % 4);
    pat++;
    host_a15 = a[1];
    host_a14 = a[0];
    q.push_back(model(c, n, a[1], a[0], in_rst, swapped));
  endtask

  // Monitor: compare each queued item after outputs settle.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (rom_ce_n !== e.ce_n) begin
          bad++;
          $display("FAIL %s rom_ce_n act=%0b exp=%0b n=%0d", e.tag, rom_ce_n, e.ce_n, n);
        end
        total++;
        if (bank_addr !== e.bank) begin
          bad++;
          $display("FAIL %s bank_addr act=%0d exp=%0d n=%0d", e.tag, bank_addr, e.bank, n);
        end
        total++;
        if (cart_present !== e.pres) begin
          bad++;
          $display("FAIL %s cart_present act=%0b exp=%0b n=%0d", e.tag, cart_present, e.pres, n);
        end
      end
    end
  end

  task automatic run_cfg(int c, int cycles, int swap_at, int swap_cfg);
    @(negedge clk);
    rst_n   = 1'b0;
    cfg_sel = 3'(c);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive(c, 1'b1, 1'b0);   // R9 reset state
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      if (j == swap_at) cfg_sel = 3'(swap_cfg);   // R8 late change
      drive(c, 1'b0, (swap_at >= 0) && (j >= swap_at));
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    host_a15 = 1'b0;
    host_a14 = 1'b0;
    cfg_sel  = 3'd0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 8; c++) run_cfg(c, 5 * PER + 20, -1, 0);
    run_cfg(1, 60, -1, 0);          // R9 restart from mid-sequence
    run_cfg(4, 5 * PER + 20, 10, 0); // R8
    run_cfg(0, 5 * PER + 20, 30, 4); // R8
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule